// File: doc/BRIEF.md
# Sixteen-Opcode Register Machine Core

This block is a small multi-cycle 16-bit processor. It has sixteen 16-bit general registers, the first of which always reads zero, and one 256-word by 16-bit memory that holds both code and data. Every instruction is a single word. The core fetches the word at the program counter and then decodes and executes it in the next cycle. It supports arithmetic and logic between registers, address-immediate loads, direct and register-indirect loads and stores, conditional branches, a register jump and a jump-and-link.

Software is placed in memory through a host write port while `rst_n` is held low. After reset is released, the core starts at address 0x10 and runs until it executes the halt opcode. Word address 0xFF is not storage. A load from 0xFF pulls the next word from an input valid/ready stream and waits while no word is offered. A store to 0xFF sends a one-cycle word on an output valid stream.

Top module: `tiny16_core`

## Requirements
- R1: While reset is applied, `halted`, `out_valid` and `in_ready` are 0, and host writes (`host_we`, `host_addr`, `host_wdata`) fill memory. After release, the first instruction fetched is at address 0x10.
- R2: An instruction word has these fields: bits 15:12 are the opcode, bits 11:8 the destination register d, bits 7:4 the source s, bits 3:0 the source t, and bits 7:0 the 8-bit address.
- R3: Opcodes 0x1 to 0x6 write R[d] with R[s] op R[t]. The ops in that order are add, subtract, AND, XOR, shift left and logical shift right, all modulo 2^16. The shift count is bits 3:0 of R[t].
- R4: Opcode 0x7 writes the zero-extended address field into R[d]. Opcode 0x8 loads mem[addr] into R[d]. Opcode 0x9 stores R[d] into mem[addr].
- R5: Opcode 0xA loads mem[R[t] bits 7:0] into R[d]. Opcode 0xB stores R[d] into mem[R[t] bits 7:0].
- R6: Opcode 0xC jumps to addr when R[d] is zero. Opcode 0xD jumps to addr when R[d], read as a signed number, is greater than zero. Otherwise execution falls through.
- R7: Opcode 0xE sets the program counter to bits 7:0 of R[d]. Opcode 0xF writes the address of the following instruction into R[d] and then jumps to addr. The program counter is 8 bits and wraps.
- R8: Register 0 always reads zero. Writes to it have no effect.
- R9: A load whose address is 0xFF raises `in_ready`. The core holds until `in_valid` is high and then writes `in_data` into R[d]. Each accepted word is taken exactly once.
- R10: A store whose address is 0xFF gives one `out_valid` pulse, one cycle long, with `out_data` equal to R[d]. Memory is not written.
- R11: Opcode 0x0 sets `halted`. From then until the next reset the core fetches nothing more, raises no `in_ready` and sends no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Memory write strobe, honoured while the core is in reset |
| host_addr | input | 8 | Memory word address for host writes |
| host_wdata | input | 16 | Memory word for host writes |
| in_valid | input | 1 | Input stream word available |
| in_data | input | 16 | Input stream word |
| in_ready | output | 1 | Core is executing a load from 0xFF and accepts a word this cycle |
| out_valid | output | 1 | One-cycle output stream pulse |
| out_data | output | 16 | Output stream word |
| halted | output | 1 | Halt opcode executed |

## Verification
Every instruction leaves its result in a register or in memory where the ports cannot see it. A wrong register write, address or branch decision therefore only shows when a later store to 0xFF sends the wrong word, or sends it in the wrong order. That happens one to a few instructions later, or never if the program takes another path. The test programs store each result to 0xFF right after computing it. They also route control flow so that a wrong branch decision changes how many output words appear or halts the core early. A stall that is lost or duplicated shows up at once as a changed input count or output count.

// File: rtl/tiny16_pkg.sv
package tiny16_pkg;

  typedef enum logic [3:0] {
    OP_HALT = 4'h0,
    OP_ADD  = 4'h1,
    OP_SUB  = 4'h2,
    OP_AND  = 4'h3,
    OP_XOR  = 4'h4,
    OP_SHL  = 4'h5,
    OP_SHR  = 4'h6,
    OP_LDA  = 4'h7,
    OP_LD   = 4'h8,
    OP_ST   = 4'h9,
    OP_LDI  = 4'hA,
    OP_STI  = 4'hB,
    OP_BZ   = 4'hC,
    OP_BP   = 4'hD,
    OP_JR   = 4'hE,
    OP_JAL  = 4'hF
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_HALT  = 2'd2
  } state_e;

  // Instruction field positions (decoded by the core's control)
  localparam int OP_MSB = 15;
  localparam int RD_MSB = 11;
  localparam int RS_MSB = 7;
  localparam int RT_MSB = 3;

endpackage

// File: rtl/tiny16_rst_sync.sv
module tiny16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/tiny16_alu.sv
module tiny16_alu
  import tiny16_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  localparam int SHW = $clog2(DW);

  logic [SHW-1:0] sh;
  assign sh = b[SHW-1:0];

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_XOR:  y = a ^ b;
      OP_SHL:  y = a << sh;
      OP_SHR:  y = a >> sh;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/tiny16_regfile.sv
module tiny16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] ra_s,
  input  logic [RW-1:0] ra_t,
  input  logic [RW-1:0] ra_d,
  output logic [DW-1:0] rd_s,
  output logic [DW-1:0] rd_t,
  output logic [DW-1:0] rd_d
);
  logic [DW-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign q[i] = '0;
    end else begin : g_flop
      logic [DW-1:0] r;
      logic          en;
      assign en = we && (waddr == RW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  r <= '0;
        else if (en) r <= wdata;
      end
      assign q[i] = r;
    end
  end

  assign rd_s = q[ra_s];
  assign rd_t = q[ra_t];
  assign rd_d = q[ra_d];
endmodule

// File: rtl/tiny16_mem.sv
module tiny16_mem #(
  parameter int DW = 16,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/tiny16_core.sv
module tiny16_core
  import tiny16_pkg::*;
#(
  parameter int          DW          = 16,
  parameter int          NREG        = 16,
  parameter int          AW          = 8,
  parameter logic [7:0]  START_PC    = 8'h10,
  parameter logic [7:0]  IO_ADDR     = 8'hFF,
  parameter int          SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          halted
);
  localparam int RW = $clog2(NREG);

  logic core_rst_n;
  logic host_mode;

  tiny16_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (core_rst_n)
  );
  assign host_mode = !core_rst_n;

  // State registers and next-state values
  state_e        state_q, state_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [DW-1:0] ir_q, ir_d;
  logic          ov_q, ov_d;
  logic [DW-1:0] od_q, od_d;
  logic          ir_en;

  // Decode
  op_e           op;
  logic [RW-1:0] f_d, f_s, f_t;
  logic [AW-1:0] f_addr;
  assign op     = op_e'(ir_q[OP_MSB -: 4]);
  assign f_d    = ir_q[RD_MSB -: RW];
  assign f_s    = ir_q[RS_MSB -: RW];
  assign f_t    = ir_q[RT_MSB -: RW];
  assign f_addr = ir_q[AW-1:0];

  // Register file
  logic          rf_we;
  logic [DW-1:0] rf_wdata;
  logic [DW-1:0] s_val, t_val, d_val;

  tiny16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (core_rst_n),
    .we    (rf_we),
    .waddr (f_d),
    .wdata (rf_wdata),
    .ra_s  (f_s),
    .ra_t  (f_t),
    .ra_d  (f_d),
    .rd_s  (s_val),
    .rd_t  (t_val),
    .rd_d  (d_val)
  );

  // ALU
  logic [DW-1:0] alu_y;
  tiny16_alu #(.DW(DW)) u_alu (
    .op (op),
    .a  (s_val),
    .b  (t_val),
    .y  (alu_y)
  );

  // Memory and its address / write muxing
  logic          is_indirect;
  logic [AW-1:0] data_addr;
  logic          io_hit;
  logic          core_mem_we;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  assign is_indirect = (op == OP_LDI) || (op == OP_STI);
  assign data_addr   = is_indirect ? t_val[AW-1:0] : f_addr;
  assign io_hit      = (data_addr == IO_ADDR);
  assign mem_raddr   = (state_q == ST_FETCH) ? pc_q : data_addr;
  assign mem_we      = host_mode ? host_we    : core_mem_we;
  assign mem_waddr   = host_mode ? host_addr  : data_addr;
  assign mem_wdata   = host_mode ? host_wdata : d_val;

  tiny16_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  logic          in_ready_c;
  logic          d_positive;
  assign d_positive = (d_val != '0) && !d_val[DW-1];

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    pc_d        = pc_q;
    ir_d        = mem_rdata;
    ir_en       = 1'b0;
    rf_we       = 1'b0;
    rf_wdata    = alu_y;
    ov_d        = 1'b0;
    od_d        = od_q;
    core_mem_we = 1'b0;
    in_ready_c  = 1'b0;
    case (state_q)
      ST_FETCH: begin
        ir_en   = 1'b1;
        pc_d    = pc_q + AW'(1);
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        case (op)
          OP_HALT: state_d = ST_HALT;
          OP_ADD, OP_SUB, OP_AND, OP_XOR, OP_SHL, OP_SHR: begin
            rf_we    = 1'b1;
            rf_wdata = alu_y;
          end
          OP_LDA: begin
            rf_we    = 1'b1;
            rf_wdata = {{(DW-AW){1'b0}}, f_addr};
          end
          OP_LD, OP_LDI: begin
            if (io_hit) begin
              in_ready_c = 1'b1;
              if (in_valid) begin
                rf_we    = 1'b1;
                rf_wdata = in_data;
              end else begin
                state_d  = ST_EXEC;
              end
            end else begin
              rf_we    = 1'b1;
              rf_wdata = mem_rdata;
            end
          end
          OP_ST, OP_STI: begin
            if (io_hit) begin
              ov_d = 1'b1;
              od_d = d_val;
            end else begin
              core_mem_we = 1'b1;
            end
          end
          OP_BZ:  if (d_val == '0) pc_d = f_addr;
          OP_BP:  if (d_positive)  pc_d = f_addr;
          OP_JR:  pc_d = d_val[AW-1:0];
          OP_JAL: begin
            rf_we    = 1'b1;
            rf_wdata = {{(DW-AW){1'b0}}, pc_q};
            pc_d     = f_addr;
          end
          default: state_d = ST_HALT;
        endcase
      end
      default: state_d = ST_HALT;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= START_PC[AW-1:0];
      ov_q    <= 1'b0;
      od_q    <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ov_q    <= ov_d;
      od_q    <= od_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) ir_q <= '0;
    else if (ir_en)  ir_q <= ir_d;
  end

  assign in_ready  = in_ready_c;
  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign halted    = (state_q == ST_HALT);

  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    halted |=> (halted && $stable(pc_q)));

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    halted |-> (!in_ready && !out_valid));

  // R9
  io_stall_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (in_ready && !in_valid) |=> ($stable(pc_q) && $stable(ir_q) && in_ready));

  // R10
  out_pulse_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    out_valid |=> !out_valid);

endmodule

// File: tb/tb_tiny16_core.sv
`timescale 1ns/1ps
module tb_tiny16_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic [7:0]  host_addr;
  logic [15:0] host_wdata;
  logic        in_valid;
  logic [15:0] in_data;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_data;
  logic        halted;

  always #4 clk = ~clk;

  tiny16_core dut (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .halted(halted)
  );

  int total = 0;
  int bad   = 0;

  // Operand pairs {a, b}; each is run through all six R3 operations.
  localparam logic [31:0] PAIRS [0:5] = '{
    32'h0003_0004, 32'hFFFF_0001, 32'h8001_0011,
    32'h1234_00F4, 32'h0000_0000, 32'hAAAA_555F
  };

  // Program 1 at 0x10: read a, b; output add..shr; branch-zero on R0 back to 0x10.
  localparam logic [15:0] PROG1 [0:14] = '{
    16'h81FF, 16'h82FF, 16'h1312, 16'h93FF, 16'h2312, 16'h93FF, 16'h3312,
    16'h93FF, 16'h4312, 16'h93FF, 16'h5312, 16'h93FF, 16'h6312, 16'h93FF,
    16'hC010
  };

  // Program 2 at 0x10..0x31: memory, indirect, R0, branches, jumps, halt.
  localparam logic [15:0] PROG2 [0:33] = '{
    16'h7105, 16'h9140, 16'h8240, 16'h92FF, 16'h83FF, 16'hB303, 16'hA403,
    16'h94FF, 16'h7007, 16'h90FF, 16'h86FF, 16'hD620, 16'h96FF, 16'hD11F,
    16'h91FF, 16'hF730, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
    16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
    16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h97FF, 16'hE700
  };

  function automatic logic [15:0] ref_alu(input int k, input logic [15:0] a, input logic [15:0] b);
    case (k)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a ^ b;
      4: return a << b[3:0];
      default: return a >> b[3:0];
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // Input stream driver
  logic [15:0] in_vec [0:15];
  int          in_n   = 0;
  int          in_idx = 0;
  logic        gate   = 1'b0;
  logic        take   = 1'b0;

  always @(negedge clk) begin
    if (take) in_idx = in_idx + 1;
    in_valid = gate && (in_idx < in_n);
    in_data  = (in_idx < 16) ? in_vec[in_idx] : 16'h0;
    take     = in_ready && in_valid;
  end

  // Output stream monitor
  logic [15:0] log_q [0:63];
  int          out_cnt = 0;

  always @(negedge clk) begin
    if (out_valid === 1'b1) begin
      if (out_cnt < 64) log_q[out_cnt] = out_data;
      out_cnt = out_cnt + 1;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1", {15'd0, halted},    16'h0);
    chk("R1", {15'd0, out_valid}, 16'h0);
    chk("R1", {15'd0, in_ready},  16'h0);

    // Low memory holds halts, so a wrong start address stops the core (R1)
    for (int a = 0; a < 16; a++) host_write(8'(a), 16'h0000);
    for (int i = 0; i < 15; i++) host_write(8'(16 + i), PROG1[i]);
    for (int p = 0; p < 6; p++) begin
      in_vec[2*p]   = PAIRS[p][31:16];
      in_vec[2*p+1] = PAIRS[p][15:0];
    end
    in_n = 12; in_idx = 0; take = 1'b0; out_cnt = 0; gate = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;

    for (int c = 0; c < 5000 && out_cnt < 36; c++) @(negedge clk);
    repeat (20) @(negedge clk);

    // Table walk: R3 results for every pair and operation (R2 field layout)
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 6; k++) begin
        chk("R3", log_q[p*6+k], ref_alu(k, PAIRS[p][31:16], PAIRS[p][15:0]));
      end
    end
    chk("R2", log_q[0], 16'h0007);
    chk("R1", {15'd0, halted}, 16'h0);
    // R6: branch-zero on R0 looped six times; R10 one word per pulse
    chk("R6", 16'(out_cnt), 16'd36);
    chk("R10", 16'(out_cnt), 16'd36);
    // R9: stream exhausted, core waits with in_ready high
    chk("R9", {15'd0, in_ready}, 16'h1);
    chk("R9", 16'(in_idx), 16'd12);

    // Second program
    @(negedge clk);
    rst_n = 1'b0; gate = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", {15'd0, in_ready}, 16'h0);
    for (int i = 0; i < 34; i++) host_write(8'(16 + i), PROG2[i]);
    in_vec[0] = 16'h1241; in_vec[1] = 16'h8000;
    in_n = 2; in_idx = 0; take = 1'b0; out_cnt = 0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int c = 0; c < 500 && in_ready !== 1'b1; c++) @(negedge clk);
    repeat (10) @(negedge clk);
    // R9: stall while no input is offered
    chk("R9", 16'(out_cnt), 16'd1);
    chk("R9", {15'd0, in_ready}, 16'h1);
    chk("R11", {15'd0, halted}, 16'h0);
    gate = 1'b1;

    for (int c = 0; c < 2000 && halted !== 1'b1; c++) @(negedge clk);
    chk("R4", log_q[0], 16'h0005);
    chk("R5", log_q[1], 16'h1241);
    chk("R8", log_q[2], 16'h0000);
    chk("R6", log_q[3], 16'h8000);
    chk("R7", log_q[4], 16'h0020);
    chk("R11", {15'd0, halted}, 16'h1);
    repeat (30) @(negedge clk);
    chk("R11", 16'(out_cnt), 16'd5);
    chk("R11", {15'd0, in_ready}, 16'h0);
    chk("R9", 16'(in_idx), 16'd2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule